// File: doc/BRIEF.md
# SPI Target Byte Buffer with Sticky Status Flags

This block is the receive/transmit end of an SPI target (slave) link. An external controller selects it with an active-low chip select and clocks a byte in on the data-in pin while the block clocks a byte out on the data-out pin. Every completed byte lands in one holding buffer. A register-style host port reads that buffer, writes the next outgoing byte, clears two error flags and sets or clears a module-enable bit.

The block keeps three status flags. The buffer-full flag says an unread byte is waiting. The collision flag records a host write made while that byte was still unread. The overflow flag records a byte that finished arriving while the buffer was still full. Turning the enable bit off stops the shifter but leaves all three flags and the buffer as they were. So a byte left unread before a disable is still there after re-enable, and the next host write or the next received byte raises collision or overflow. Software must drain the buffer and clear the flags before it disables the block if it wants a clean restart.

The link runs in SPI mode 0 only, most significant bit first. The SPI pins are brought into the system clock domain through two-flop synchronisers. Clock edges are found there, so the system clock must run several times faster than the serial clock.

Top module: `spi_tgt_flagbuf`

## Requirements
- R1: While enabled and selected, data-in is sampled on each rising serial clock, MSB first. On the falling clock that ends the eighth bit, the byte is stored in the holding buffer, `flag_full` becomes 1 and `host_rdata` shows the byte.
- R2: A host write made while `flag_full` is 0 loads the outgoing byte. That byte appears on `spi_miso` MSB first: bit 7 before the first rising clock of the selection, and each later bit after a falling clock.
- R3: A one-cycle `host_rd` pulse clears `flag_full`. `host_rdata` always shows the holding buffer.
- R4: If a byte completes while `flag_full` is 1, `flag_ovf` becomes 1, the new byte is discarded and the buffer keeps the earlier unread byte.
- R5: A host write while `flag_full` is 1 sets `flag_col` and is dropped. The shifter keeps its previous contents, so the next byte sent out is the last byte shifted in.
- R6: `flag_col` and `flag_ovf` stay set until their own clear pulse (`host_clr_col`, `host_clr_ovf`). Each clear affects only its own flag, and clears work while the block is disabled.
- R7: While `en_q` is 0, serial clock edges are ignored, no byte completes, the buffer is unchanged and `spi_miso` is driven 0. `spi_miso` is also 0 while chip select is high.
- R8: Writing the enable bit changes neither the flags nor the buffer. After re-enable with a stale full buffer, a host write raises `flag_col` and a received byte raises `flag_ovf`.
- R9: Raising chip select in the middle of a byte discards the partial bits. The next selection starts a fresh eight-bit count.
- R10: A synchronous active-low reset clears all three flags, the enable bit, the buffer and the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the controller (idle low) |
| spi_mosi | input | 1 | Serial data in |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data out, 0 when disabled or deselected |
| host_wr | input | 1 | Write pulse for the outgoing byte |
| host_wdata | input | 8 | Outgoing byte |
| host_rd | input | 1 | Read pulse, clears the buffer-full flag |
| host_rdata | output | 8 | Holding buffer contents |
| host_clr_col | input | 1 | Clear pulse for the collision flag |
| host_clr_ovf | input | 1 | Clear pulse for the overflow flag |
| host_en_we | input | 1 | Write strobe for the enable bit |
| host_en_wdata | input | 1 | New enable value |
| en_q | output | 1 | Current enable bit |
| flag_full | output | 1 | Buffer-full flag |
| flag_col | output | 1 | Write-collision flag |
| flag_ovf | output | 1 | Receive-overflow flag |

## Verification
Host pulses take effect at the next clock edge, so flags and buffer are checked one cycle after the pulse. A serial pin change passes two synchroniser flops and one edge-detect flop, so a completed byte or a shifted output bit is due on the third clock edge after the pin is sampled. The bench holds each serial pin level for eight system clocks and samples flags and `spi_miso` only at the end of those windows, well past that three-edge delay. All inputs are driven and all outputs sampled on the falling system clock edge.

// File: rtl/sfb_pkg.sv
// Shared types for the SPI target byte buffer.
// Assumes: nothing beyond standard SystemVerilog packages.
package sfb_pkg;

    // The three status flags kept together in one register.
    typedef struct packed {
        logic full;
        logic col;
        logic ovf;
    } sfb_flags_t;

    localparam int unsigned SFB_DEF_WIDTH = 8;

endpackage

// File: rtl/sfb_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes: each bit is independent, so no bus coherence is needed.
// RST_VAL gives the idle level of each bit.
module sfb_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[i]}};
            end else begin
                chain <= {chain[STAGES-2:0], d[i]};
            end
        end

        assign q[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/sfb_shifter.sv
// Mode-0 SPI target shift register, MSB first. Data-in is sampled on the
// rising serial clock. The shared shift register moves on the falling clock,
// which also ends each bit. Assumes synchronised inputs and a system clock
// several times faster than the serial clock. A host load must not happen
// in the middle of a byte.
module sfb_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         sck_s,
    input  logic         mosi_s,
    input  logic         cs_n_s,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         done,
    output logic [W-1:0] rx_word,
    output logic         miso
);

    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          sck_d;
    logic          smp;
    logic [W-1:0]  sr;
    logic [CW-1:0] cnt;
    logic          active;
    logic          rise;
    logic          fall;

    assign active  = en & ~cs_n_s;
    assign rise    = sck_s & ~sck_d;
    assign fall    = ~sck_s & sck_d;
    assign done    = active & fall & (cnt == LAST);
    assign rx_word = {sr[W-2:0], smp};
    assign miso    = active & sr[W-1];

    // Track the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Sample data-in, shift, count bits, or take a host load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            smp <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            sr  <= load_data;
            cnt <= '0;
        end else if (active) begin
            if (rise) smp <= mosi_s;
            if (fall) begin
                sr  <= {sr[W-2:0], smp};
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    // R7: a disabled shifter keeps its contents unless the host loads it.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(sr));

    // R2: a host load places the outgoing byte in the shift register.
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sr == $past(load_data)));

    // R9: a deselected shifter begins the next byte from bit zero.
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && !load) |=> (cnt == '0));

endmodule

// File: rtl/sfb_flags.sv
// Holding buffer and the three sticky status flags. Assumes rx_done is a
// one-cycle pulse. Clear pulses are applied before new events in the same
// cycle, so an event that coincides with its clear still sets the flag.
module sfb_flags
    import sfb_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_done,
    input  logic [W-1:0] rx_word,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic         clr_col,
    input  logic         clr_ovf,
    output logic [W-1:0] hold,
    output sfb_flags_t   flags,
    output logic         wr_accept
);

    assign wr_accept = host_wr & ~flags.full;

    // Update the buffer and flags from host actions and received bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= '0;
            flags <= '0;
        end else begin
            if (clr_col) flags.col  <= 1'b0;
            if (clr_ovf) flags.ovf  <= 1'b0;
            if (host_rd) flags.full <= 1'b0;
            if (host_wr && flags.full) flags.col <= 1'b1;
            if (rx_done) begin
                if (flags.full) begin
                    flags.ovf <= 1'b1;
                end else begin
                    hold       <= rx_word;
                    flags.full <= 1'b1;
                end
            end
        end
    end

    // R1: a byte arriving into an empty buffer is stored and marked full.
    a_r1_store: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !flags.full && !host_rd) |=> (flags.full && hold == $past(rx_word)));

    // R4: an overflowing byte is discarded and the overflow flag set.
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && flags.full) |=> ($stable(hold) && flags.ovf));

    // R5: a write into a full buffer raises the collision flag.
    a_r5_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && flags.full) |=> flags.col);

    // R6: collision and overflow flags persist until their own clear.
    a_r6_col_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.col && !clr_col) |=> flags.col);
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.ovf && !clr_ovf) |=> flags.ovf);

endmodule

// File: rtl/spi_tgt_flagbuf.sv
// SPI target byte buffer top: synchroniser, mode-0 shifter, holding buffer
// with sticky flags, and the enable bit. Assumes the system clock is at least
// six times the serial clock. The enable bit gates only the shifter; flags
// and buffer keep their values across enable changes.
module spi_tgt_flagbuf
    import sfb_pkg::*;
#(
    parameter int unsigned W           = SFB_DEF_WIDTH,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spi_sck,
    input  logic         spi_mosi,
    input  logic         spi_cs_n,
    output logic         spi_miso,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         host_rd,
    output logic [W-1:0] host_rdata,
    input  logic         host_clr_col,
    input  logic         host_clr_ovf,
    input  logic         host_en_we,
    input  logic         host_en_wdata,
    output logic         en_q,
    output logic         flag_full,
    output logic         flag_col,
    output logic         flag_ovf
);

    logic         sck_s;
    logic         mosi_s;
    logic         cs_n_s;
    logic         rx_done;
    logic [W-1:0] rx_word;
    logic         wr_accept;
    sfb_flags_t   flags;

    sfb_sync #(
        .N      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_cs_n, spi_mosi, spi_sck}),
        .q    ({cs_n_s, mosi_s, sck_s})
    );

    // Hold the module-enable bit written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= 1'b0;
        else if (host_en_we) en_q <= host_en_wdata;
    end

    sfb_shifter #(.W(W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .cs_n_s   (cs_n_s),
        .load     (wr_accept),
        .load_data(host_wdata),
        .done     (rx_done),
        .rx_word  (rx_word),
        .miso     (spi_miso)
    );

    sfb_flags #(.W(W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_done  (rx_done),
        .rx_word  (rx_word),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .clr_col  (host_clr_col),
        .clr_ovf  (host_clr_ovf),
        .hold     (host_rdata),
        .flags    (flags),
        .wr_accept(wr_accept)
    );

    assign flag_full = flags.full;
    assign flag_col  = flags.col;
    assign flag_ovf  = flags.ovf;

    // R8: an enable write alone leaves every flag unchanged.
    a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en_we && !host_wr && !host_rd && !host_clr_col && !host_clr_ovf && !rx_done)
        |=> $stable(flags));

    // R7: a disabled block drives data-out low.
    a_r7_miso_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !spi_miso);

endmodule

// File: tb/spi_tgt_flagbuf_test.sv
`timescale 1ns/1ps
module spi_tgt_flagbuf_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic       miso;
    logic       wr = 1'b0, rd = 1'b0, clr_col = 1'b0, clr_ovf = 1'b0;
    logic       en_we = 1'b0, en_wd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       en_q, full, col, ovf;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_tgt_flagbuf uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .spi_miso(miso), .host_wr(wr), .host_wdata(wdata), .host_rd(rd),
        .host_rdata(rdata), .host_clr_col(clr_col), .host_clr_ovf(clr_ovf),
        .host_en_we(en_we), .host_en_wdata(en_wd), .en_q(en_q),
        .flag_full(full), .flag_col(col), .flag_ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [7:0] d);
        @(negedge clk); wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk); en_we = 1'b1; en_wd = v;
        @(negedge clk); en_we = 1'b0;
    endtask

    task automatic do_clr(input logic c, input logic o);
        @(negedge clk); clr_col = c; clr_ovf = o;
        @(negedge clk); clr_col = 1'b0; clr_ovf = 1'b0;
    endtask

    // Controller side of one selection, nbits clocks, MSB first, mode 0.
    task automatic xfer(input logic [7:0] m, output logic [7:0] r, input int nbits);
        r = '0;
        cs_n = 1'b0; tick(8);
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = m[i]; tick(8);
            r[i] = miso;
            sck = 1'b1; tick(8);
            sck = 1'b0;
        end
        tick(8); cs_n = 1'b1; tick(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        tick(4); rst_n = 1'b1; tick(2);
        // R10 reset state
        chk(full == 0 && col == 0 && ovf == 0, "R10 flags after reset", {full, col, ovf}, 0);
        chk(en_q == 0 && miso == 0, "R10 enable and miso after reset", {en_q, miso}, 0);
        chk(rdata == 8'h00, "R10 buffer after reset", rdata, 0);

        set_en(1'b1);
        // R1 R2 R3 sweep over all received values
        for (int v = 0; v < 256; v++) begin
            logic [7:0] tx;
            tx = 8'((v * 37 + 11) & 255);
            pulse_wr(tx);
            xfer(8'(v), r, 8);
            chk(r == tx, "R2 sent byte", r, tx);
            chk(full == 1'b1, "R1 full after byte", full, 1);
            chk(rdata == 8'(v), "R1 received byte", rdata, v);
            pulse_rd();
            chk(full == 1'b0, "R3 read clears full", full, 0);
            chk(rdata == 8'(v), "R3 buffer after read", rdata, v);
        end
        chk(col == 0 && ovf == 0, "R6 no flags in clean sweep", {col, ovf}, 0);

        // R4 overflow keeps earlier byte
        pulse_wr(8'h3C);
        xfer(8'h81, r, 8);
        xfer(8'h7E, r, 8);
        chk(ovf == 1'b1, "R4 overflow set", ovf, 1);
        chk(rdata == 8'h81, "R4 earlier byte kept", rdata, 8'h81);
        chk(full == 1'b1, "R4 full stays", full, 1);

        // R5 collision drops the write
        pulse_wr(8'hC3);
        chk(col == 1'b1, "R5 collision set", col, 1);
        chk(rdata == 8'h81, "R5 buffer unchanged", rdata, 8'h81);
        pulse_rd();
        xfer(8'h55, r, 8);
        chk(r == 8'h7E, "R5 dropped write not sent", r, 8'h7E);
        chk(rdata == 8'h55 && full == 1'b1, "R5 next byte received", rdata, 8'h55);

        // R6 stickiness
        tick(40);
        chk(col == 1'b1 && ovf == 1'b1, "R6 flags persist", {col, ovf}, 3);

        // R8 disable keeps flags
        set_en(1'b0);
        chk(en_q == 1'b0, "R8 enable cleared", en_q, 0);
        chk(full == 1 && col == 1 && ovf == 1, "R8 flags kept on disable", {full, col, ovf}, 7);

        // R7 disabled shifter ignores traffic
        xfer(8'hF0, r, 8);
        chk(r == 8'h00, "R7 miso low while disabled", r, 0);
        chk(rdata == 8'h55, "R7 buffer unchanged while disabled", rdata, 8'h55);
        chk(full == 1 && col == 1 && ovf == 1, "R7 flags unchanged while disabled", {full, col, ovf}, 7);

        // R6 individual clears, while disabled
        do_clr(1'b1, 1'b0);
        chk(col == 1'b0 && ovf == 1'b1, "R6 clear col only", {col, ovf}, 1);
        do_clr(1'b0, 1'b1);
        chk(col == 1'b0 && ovf == 1'b0, "R6 clear ovf", {col, ovf}, 0);

        // R8 stale full buffer after re-enable
        set_en(1'b1);
        chk(full == 1'b1, "R8 full kept on enable", full, 1);
        pulse_wr(8'h11);
        chk(col == 1'b1, "R8 collision after re-enable", col, 1);
        xfer(8'h22, r, 8);
        chk(ovf == 1'b1, "R8 overflow after re-enable", ovf, 1);
        chk(rdata == 8'h55, "R8 stale byte kept", rdata, 8'h55);

        // R9 partial byte discarded
        do_clr(1'b1, 1'b1);
        pulse_rd();
        pulse_wr(8'hA0);
        xfer(8'hFF, r, 4);
        chk(full == 1'b0, "R9 partial byte not stored", full, 0);
        pulse_wr(8'h96);
        xfer(8'h5A, r, 8);
        chk(r == 8'h96, "R9 fresh byte sent", r, 8'h96);
        chk(rdata == 8'h5A && full == 1'b1, "R9 fresh byte received", rdata, 8'h5A);

        // R10 reset clears flags and enable
        pulse_wr(8'h01);
        chk(col == 1'b1, "R10 collision before reset", col, 1);
        @(negedge clk); rst_n = 1'b0;
        tick(2); rst_n = 1'b1; tick(1);
        chk(full == 0 && col == 0 && ovf == 0, "R10 flags cleared by reset", {full, col, ovf}, 0);
        chk(en_q == 1'b0 && rdata == 8'h00, "R10 enable and buffer cleared", {en_q, rdata}, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule